// File: doc/BRIEF.md
# Delayed Write Queue

This block handles the delayed-write path of a bus bridge, used for single-word I/O writes and configuration writes. The initiator side presents a simplified request: command, address, address parity, active-low byte enables, one data word, data parity, and a flag that marks a request for more than one word. The block answers one cycle later with a response code. The first time a write is seen, the answer is always a retry. The block stores the write and replays it to the target side by itself.

The target side uses a request that is held high until a done pulse arrives with a termination code. Target retries cause the same write to be issued again. An attempt counter stops this after a selectable number of attempts, and the block then flags a system error. When the initiator later repeats exactly the same write, and the completed entry is at the head of the queue, the block answers with an accept and frees the entry.

Top module: `dw_queue`

## Requirements
- R1: Only command codes 4'b0011 (I/O write) and 4'b1011 (configuration write) are handled. Any other command gets no response (resp_valid stays low) and adds no entry.
- R2: A new handled write is answered in the next cycle with resp_valid high and resp_code 2'b01 (retry). Its command, address, address parity, byte enables, data and data parity are stored and later appear unchanged on the tgt_* outputs.
- R3: The queue holds DEPTH entries (4 by default), and q_full is high when all are in use. A new write that arrives while the queue is full, or that matches the address and command of an entry already queued, gets a retry and is not added.
- R4: tgt_req rises only for the head entry, and only in the cycle after order_ok was sampled high.
- R5: When the target ends an attempt with tgt_term 2'b01 (retry), tgt_req stays high and the same write is presented again.
- R6: A repeat of a queued write that arrives before the target has completed it gets a retry and adds no entry.
- R7: A repeat that matches the completed head entry (same command, address and byte enables) gets resp_code 2'b10 (accept), or 2'b11 (accept with disconnect) when req_multi is set. The entry is then removed.
- R8: Data bytes whose active-low enable bit is 1 are left out of the repeat comparison. A difference in an enabled byte gives a retry.
- R9: The attempt limit is 2^SHORT_LOG when cfg_long_limit is 0 and 2^LONG_LOG when it is 1. The target retry that reaches the limit drops the entry, ends tgt_req and pulses sys_err for one cycle. serr_o follows that pulse only when serr_en is 1.
- R10: A target termination of 2'b10 (error) drops the head entry and pulses sys_err for one cycle.
- R11: The attempt counter is cleared whenever an entry leaves the head, so each new head entry starts with the full attempt budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Initiator request present this cycle |
| req_cmd | input | 4 | Bus command |
| req_addr | input | AW | Address |
| req_apar | input | 1 | Address parity, carried through |
| req_be_n | input | DW/8 | Active-low byte enables |
| req_data | input | DW | First data word |
| req_dpar | input | 1 | Data parity, carried through |
| req_multi | input | 1 | Initiator asks for more than one word |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 01 retry, 10 accept, 11 accept with disconnect |
| order_ok | input | 1 | Posted-write ordering satisfied |
| tgt_req | output | 1 | Write attempt request on target side |
| tgt_cmd | output | 4 | Head entry command |
| tgt_addr | output | AW | Head entry address |
| tgt_apar | output | 1 | Head entry address parity |
| tgt_be_n | output | DW/8 | Head entry byte enables |
| tgt_data | output | DW | Head entry data |
| tgt_dpar | output | 1 | Head entry data parity |
| tgt_done | input | 1 | Attempt finished this cycle |
| tgt_term | input | 2 | 00 completed, 01 retry, 10 error |
| cfg_long_limit | input | 1 | Select the long attempt limit |
| serr_en | input | 1 | Allow serr_o |
| sys_err | output | 1 | One-cycle pulse when an entry is dropped |
| serr_o | output | 1 | System error, gated by serr_en |
| q_full | output | 1 | All entries in use |
| q_empty | output | 1 | No entries in use |

## Verification
The assertions check the following on every cycle:
- A response only follows a request.
- Unhandled commands never get a response.
- tgt_req rises only after order_ok was high.
- The target-side fields stay steady while an attempt is open.
- An error termination always produces sys_err.
- A disconnect is only given when more than one word was asked for.

Some behaviour can only be shown by the bench scenarios. These are: whether a write was really kept out of the queue, which the bench sees from how q_empty and q_full behave during a later drain; masked versus unmasked data comparison; and the exact attempt count at which both limits fire, including the counter clearing for a new head entry.

// File: rtl/dw_queue.sv
module dw_queue #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int SHORT_LOG = 24,
  parameter int LONG_LOG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [3:0]      req_cmd,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_apar,
  input  logic [DW/8-1:0] req_be_n,
  input  logic [DW-1:0]   req_data,
  input  logic            req_dpar,
  input  logic            req_multi,
  output logic            resp_valid,
  output logic [1:0]      resp_code,
  input  logic            order_ok,
  output logic            tgt_req,
  output logic [3:0]      tgt_cmd,
  output logic [AW-1:0]   tgt_addr,
  output logic            tgt_apar,
  output logic [DW/8-1:0] tgt_be_n,
  output logic [DW-1:0]   tgt_data,
  output logic            tgt_dpar,
  input  logic            tgt_done,
  input  logic [1:0]      tgt_term,
  input  logic            cfg_long_limit,
  input  logic            serr_en,
  output logic            sys_err,
  output logic            serr_o,
  output logic            q_full,
  output logic            q_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BW = DW / 8;
  localparam int CW = LONG_LOG + 1;
  localparam logic [3:0] CMD_IOW = 4'b0011;
  localparam logic [3:0] CMD_CFW = 4'b1011;
  localparam logic [1:0] ST_PEND = 2'd0, ST_FLY = 2'd1, ST_DONE = 2'd2;

  logic [3:0]    q_cmd  [DEPTH];
  logic [AW-1:0] q_addr [DEPTH];
  logic          q_apar [DEPTH];
  logic [BW-1:0] q_be   [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic          q_dpar [DEPTH];
  logic [DEPTH-1:0] q_vld, hit;
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [PW:0]   count;
  logic [1:0]    hstate;
  logic [CW-1:0] rcnt, limit;
  logic [DW-1:0] mask;

  logic is_dw, any_hit, head_match, push, accept, pop;
  logic t_ok, t_retry, t_err, lim_hit, drop, issue;

  assign is_dw = (req_cmd == CMD_IOW) || (req_cmd == CMD_CFW);

  for (genvar b = 0; b < BW; b++) begin : g_mask
    assign mask[8*b +: 8] = {8{~req_be_n[b]}};
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign hit[i] = q_vld[i] && q_addr[i] == req_addr && q_cmd[i] == req_cmd;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_vld[i]  <= 1'b0;
        q_cmd[i]  <= '0;
        q_addr[i] <= '0;
        q_apar[i] <= 1'b0;
        q_be[i]   <= '0;
        q_data[i] <= '0;
        q_dpar[i] <= 1'b0;
      end else if (push && wr_ptr == PW'(i)) begin
        q_vld[i]  <= 1'b1;
        q_cmd[i]  <= req_cmd;
        q_addr[i] <= req_addr;
        q_apar[i] <= req_apar;
        q_be[i]   <= req_be_n;
        q_data[i] <= req_data;
        q_dpar[i] <= req_dpar;
      end else if (pop && rd_ptr == PW'(i)) begin
        q_vld[i] <= 1'b0;
      end
    end
  end

  assign q_full  = (count == (PW+1)'(DEPTH));
  assign q_empty = (count == '0);
  assign any_hit = |hit;
  assign head_match = hit[rd_ptr] && hstate == ST_DONE && q_be[rd_ptr] == req_be_n &&
                      ((q_data[rd_ptr] ^ req_data) & mask) == '0;
  assign push   = req_valid && is_dw && !any_hit && !q_full;
  assign accept = req_valid && is_dw && head_match;

  assign t_ok    = tgt_req && tgt_done && tgt_term == 2'b00;
  assign t_retry = tgt_req && tgt_done && tgt_term == 2'b01;
  assign t_err   = tgt_req && tgt_done && tgt_term[1];
  assign limit   = cfg_long_limit ? (CW'(1) << LONG_LOG) : (CW'(1) << SHORT_LOG);
  assign lim_hit = t_retry && (rcnt + CW'(1) == limit);
  assign drop    = t_err || lim_hit;
  assign pop     = accept || drop;
  assign issue   = !q_empty && hstate == ST_PEND && order_ok;

  assign tgt_cmd  = q_cmd[rd_ptr];
  assign tgt_addr = q_addr[rd_ptr];
  assign tgt_apar = q_apar[rd_ptr];
  assign tgt_be_n = q_be[rd_ptr];
  assign tgt_data = q_data[rd_ptr];
  assign tgt_dpar = q_dpar[rd_ptr];
  assign serr_o   = sys_err && serr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= 2'b00;
      sys_err    <= 1'b0;
      tgt_req    <= 1'b0;
      hstate     <= ST_PEND;
      rcnt       <= '0;
      count      <= '0;
      rd_ptr     <= '0;
      wr_ptr     <= '0;
    end else begin
      resp_valid <= req_valid && is_dw;
      resp_code  <= !(req_valid && is_dw) ? 2'b00 : accept ? {1'b1, req_multi} : 2'b01;
      sys_err    <= drop;
      if (issue) tgt_req <= 1'b1;
      else if (t_ok || drop) tgt_req <= 1'b0;
      if (pop) hstate <= ST_PEND;
      else if (issue) hstate <= ST_FLY;
      else if (t_ok) hstate <= ST_DONE;
      if (pop) rcnt <= '0;
      else if (t_retry) rcnt <= rcnt + CW'(1);
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
    end
  end
endmodule

module dw_queue_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [3:0]    req_cmd,
  input logic          req_multi,
  input logic          resp_valid,
  input logic [1:0]    resp_code,
  input logic          order_ok,
  input logic          tgt_req,
  input logic [AW-1:0] tgt_addr,
  input logic [DW-1:0] tgt_data,
  input logic          tgt_done,
  input logic [1:0]    tgt_term,
  input logic          sys_err
);
  // R2
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid));
  // R1
  ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(req_cmd == 4'b0011 || req_cmd == 4'b1011) |=> !resp_valid);
  // R4
  issue_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_req) |-> $past(order_ok));
  // R5
  hold_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && !tgt_done |=> tgt_req && $stable(tgt_addr) && $stable(tgt_data));
  // R10
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && tgt_done && tgt_term == 2'b10 |=> sys_err);
  // R7
  disc_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_code == 2'b11 |-> $past(req_multi));
endmodule

bind dw_queue dw_queue_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_multi(req_multi), .resp_valid(resp_valid), .resp_code(resp_code),
  .order_ok(order_ok), .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
  .tgt_done(tgt_done), .tgt_term(tgt_term), .sys_err(sys_err));

// File: tb/dw_queue_tb_top.sv
module dw_queue_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_apar = 0, req_dpar = 0, req_multi = 0;
  logic [3:0] req_cmd = 0, req_be_n = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic resp_valid; logic [1:0] resp_code;
  logic order_ok = 0, tgt_req, tgt_apar, tgt_dpar;
  logic [3:0] tgt_cmd, tgt_be_n; logic [31:0] tgt_addr, tgt_data;
  logic tgt_done = 0; logic [1:0] tgt_term = 0;
  logic cfg_long_limit = 0, serr_en = 0;
  logic sys_err, serr_o, q_full, q_empty;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dw_queue #(.SHORT_LOG(2), .LONG_LOG(3)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] cmd, input logic [31:0] addr, input logic [3:0] be,
                      input logic [31:0] data, input logic multi,
                      output logic v, output logic [1:0] code);
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = addr; req_be_n = be;
    req_data = data; req_multi = multi; req_apar = ^addr; req_dpar = ^data;
    @(negedge clk);
    v = resp_valid; code = resp_code;
    req_valid = 0;
  endtask

  task automatic answer(input logic [1:0] term);
    @(negedge clk);
    while (!tgt_req) @(negedge clk);
    tgt_done = 1; tgt_term = term;
    @(negedge clk);
    tgt_done = 0; tgt_term = 0;
  endtask

  task automatic t_reset;
    check(q_empty && !q_full, "R3", "reset empty/full", {q_full, q_empty}, 2'b01);
    check(!tgt_req && !resp_valid && !sys_err, "R2", "reset outputs",
          {tgt_req, resp_valid, sys_err}, 0);
  endtask

  task automatic t_ignore;
    logic v; logic [1:0] c;
    send(4'h7, 32'h100, 4'h0, 32'h1, 0, v, c);
    check(!v, "R1", "no response to other command", v, 0);
    check(q_empty, "R1", "no entry for other command", q_empty, 1);
  endtask

  task automatic t_basic;
    logic v; logic [1:0] c;
    order_ok = 0;
    send(4'h3, 32'h2000, 4'h0, 32'hCAFE_0001, 0, v, c);
    check(v && c == 2'b01, "R2", "first write retried", {v, c}, 3'b101);
    check(!q_empty, "R2", "entry stored", q_empty, 0);
    repeat (3) @(negedge clk);
    check(!tgt_req, "R4", "no issue without order_ok", tgt_req, 0);
    send(4'h3, 32'h2000, 4'h0, 32'hCAFE_0001, 0, v, c);
    check(c == 2'b01, "R6", "early repeat retried", c, 1);
    order_ok = 1;
    @(negedge clk);
    check(tgt_req, "R4", "issued after order_ok", tgt_req, 1);
    check(tgt_addr == 32'h2000 && tgt_data == 32'hCAFE_0001 && tgt_cmd == 4'h3 &&
          tgt_apar == ^32'h2000 && tgt_dpar == ^32'hCAFE_0001,
          "R2", "target fields", tgt_addr, 32'h2000);
    answer(2'b01);
    check(tgt_req && tgt_addr == 32'h2000, "R5", "reissue after target retry", tgt_req, 1);
    answer(2'b00);
    check(!tgt_req, "R5", "request ends on completion", tgt_req, 0);
    send(4'h3, 32'h2000, 4'h0, 32'hCAFE_0001, 0, v, c);
    check(c == 2'b10, "R7", "repeat accepted", c, 2'b10);
    check(q_empty, "R6", "only one entry was held", q_empty, 1);
  endtask

  task automatic t_mask;
    logic v; logic [1:0] c;
    order_ok = 1;
    send(4'hB, 32'h3000, 4'b1100, 32'h1122_3344, 0, v, c);
    check(c == 2'b01, "R2", "config write retried", c, 1);
    answer(2'b00);
    send(4'hB, 32'h3000, 4'b1100, 32'h1122_33FF, 1, v, c);
    check(c == 2'b01, "R8", "enabled byte differs", c, 1);
    send(4'hB, 32'h3000, 4'b1100, 32'hAABB_3344, 1, v, c);
    check(c == 2'b11, "R7", "accept with disconnect, masked bytes ignored", c, 2'b11);
    check(q_empty, "R7", "entry removed", q_empty, 1);
  endtask

  task automatic t_full;
    logic v; logic [1:0] c;
    order_ok = 0;
    for (int i = 0; i < 3; i++) send(4'h3, 32'h4000 + i*4, 4'h0, i, 0, v, c);
    check(!q_full, "R3", "three entries not full", q_full, 0);
    send(4'h3, 32'h4000, 4'h0, 32'h99, 0, v, c);
    check(c == 2'b01 && !q_full, "R3", "duplicate address not added", {c, q_full}, 3'b010);
    send(4'h3, 32'h400C, 4'h0, 3, 0, v, c);
    check(q_full, "R3", "four entries full", q_full, 1);
    send(4'h3, 32'h5000, 4'h0, 5, 0, v, c);
    check(c == 2'b01, "R3", "write while full retried", c, 1);
    order_ok = 1;
    for (int i = 0; i < 4; i++) begin
      answer(2'b00);
      send(4'h3, 32'h4000 + i*4, 4'h0, i, 0, v, c);
      check(c == 2'b10, "R3", "drain accept", c, 2'b10);
    end
    check(q_empty, "R3", "nothing extra was queued", q_empty, 1);
  endtask

  task automatic t_limit;
    logic v; logic [1:0] c;
    order_ok = 1; cfg_long_limit = 0; serr_en = 1;
    send(4'h3, 32'h6000, 4'h0, 32'h6, 0, v, c);
    for (int i = 0; i < 3; i++) answer(2'b01);
    check(!sys_err && tgt_req, "R9", "below short limit", sys_err, 0);
    answer(2'b01);
    check(sys_err && serr_o, "R9", "short limit error", {sys_err, serr_o}, 2'b11);
    check(q_empty && !tgt_req, "R9", "entry dropped", {q_empty, tgt_req}, 2'b10);
    cfg_long_limit = 1; serr_en = 0;
    send(4'h3, 32'h7000, 4'h0, 32'h7, 0, v, c);
    send(4'h3, 32'h7004, 4'h0, 32'h8, 0, v, c);
    for (int i = 0; i < 3; i++) answer(2'b01);
    answer(2'b00);
    send(4'h3, 32'h7000, 4'h0, 32'h7, 0, v, c);
    check(c == 2'b10, "R11", "first head accepted", c, 2'b10);
    for (int i = 0; i < 7; i++) answer(2'b01);
    check(!sys_err && tgt_req, "R11", "counter cleared for new head", sys_err, 0);
    answer(2'b01);
    check(sys_err && !serr_o, "R9", "long limit, serr gated", {sys_err, serr_o}, 2'b10);
  endtask

  task automatic t_error;
    logic v; logic [1:0] c;
    send(4'hB, 32'h8000, 4'h0, 32'h9, 0, v, c);
    answer(2'b10);
    check(sys_err && q_empty, "R10", "error termination drops entry", {sys_err, q_empty}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_basic();
    t_mask();
    t_full();
    t_limit();
    t_error();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule